// File: doc/BRIEF.md
# Byte-Wide Memory Chip-Enable Decoder

This block sits between a small processor core and a non-multiplexed byte-wide SRAM bus. Each access request carries a 16-bit address and a kind: opcode fetch, data read or data write. The block decodes the request into a 15-bit bus address, four active-low memory chip enables, four active-low peripheral enables and an active-low write strobe. It then plays the access out over a fixed number of clock cycles.

Three configuration inputs shape the decode. The first selects between four 32 KB SRAMs and one 128 KB SRAM. In the large case, two of the chip-enable pins carry the upper SRAM address bits. The second turns on a shared, partitioned space in which a boundary separates write-protected program storage from data storage. The third redirects data accesses to four peripheral enables, each covering a quarter of the space. Fetches at or above the program boundary are not served on the byte-wide bus. They raise an expansion flag so that the external expanded bus can take them. A power-fail input forces the whole bus to its idle level.

Top module: `bytewide_cs_decoder`

## Requirements
- R1: The small-SRAM case is `bigSram`=0. The block forms a 17-bit physical address {hi, addr}, where hi=1 only for a data access with `partMode`=0. Physical bits [16:15] = 0,1,2,3 drive `memCeN` bit 0,1,2,3 low, and only that bit. `byteAddr` is the low 15 address bits.
- R2: The large-SRAM case is `bigSram`=1, and `partMode` has no effect in it. A memory access drives `memCeN`[0] low, `memCeN`[1] equal to physical bit 16 and `memCeN`[2] equal to physical bit 15, and holds `memCeN`[3] high.
- R3: A data access (kind 1 or 2) with `periphSel`=1 drives `perEnN` bit addr[15:14] low and holds every memory chip enable high. Such an access is write-enabled.
- R4: Partitioned mode applies only when `partMode`=1 and `bigSram`=0. In it, a data write below `progBound` still pulses its chip enable, but `rwN` stays high. Data reads below the boundary are served.
- R5: An opcode fetch (kind 0) at an address >= `progBound` raises `extBus` for the whole access window. All enables stay high and `rwN` stays high during that window.
- R6: Fetches and reads (kind 1, with kind 3 treated as a read) keep their enable low for RD_CYC=4 cycles. Writes (kind 2) keep it low for WR_LOW+2=8 cycles, with `rwN` low in window cycles 1 to 6. The window starts on the clock edge that samples `reqValid`.
- R7: One edge after `pwrFail` is sampled high, all enables, `ceOnePlainN` and `rwN` are high and `extBus` is low. The access in progress is abandoned, and requests are ignored while `pwrFail` is high.
- R8: A request raised while an access window is running is ignored. The running window keeps its decode and length, and no second window follows it.
- R9: `ceOnePlainN` always equals `memCeN`[0].
- R10: After reset, all enables and `rwN` are high, `extBus` is low and `byteAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrFail | input | 1 | Power-fail or reset state, forces the bus idle |
| reqValid | input | 1 | Starts an access when the block is idle |
| reqKind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| reqAddr | input | 16 | Access address |
| bigSram | input | 1 | 1: single 128 KB SRAM, 0: four 32 KB SRAMs |
| partMode | input | 1 | Shared partitioned space (small SRAM only) |
| periphSel | input | 1 | Route data accesses to peripheral enables |
| progBound | input | 16 | Program/data boundary address |
| byteAddr | output | 15 | Byte-wide bus address |
| memCeN | output | 4 | Memory chip enables, active low (bits 1 and 2 are address bits in large mode) |
| perEnN | output | 4 | Peripheral enables, active low |
| ceOnePlainN | output | 1 | Non-backed copy of chip enable 0 |
| rwN | output | 1 | Write strobe, active low |
| extBus | output | 1 | Access belongs to the expanded bus |

## Verification
Two events can land in the same cycle as a running access window. One is a power-fail raised in the middle of a write strobe. The other is a new request arriving while a window is still active. The bench raises `pwrFail` at window cycle 3 of a write, and also together with a fresh request. It then requires the bus to go fully idle one edge later and stay idle after the fail clears. A second request is driven at window cycle 2 of each write and of a sample of reads. The bench judges it by requiring the first window's enables, strobe and length to run unchanged, and the bus to be idle right after that window.

// File: rtl/bwdec_pkg.sv
package bwdec_pkg;
  parameter int unsigned ADDR_W = 16;
  localparam int unsigned BYTE_W = ADDR_W - 1;
  localparam int unsigned N_EN   = 4;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_RSVD  = 2'd3
  } kindT;

  // strobes from control to datapath, valid for the cycle after the edge
  typedef struct packed {
    logic load;
    logic enOn;
    logic wrOn;
  } strobeT;

  typedef struct packed {
    logic              big;
    logic              memHit;
    logic [1:0]        physTop;
    logic [N_EN-1:0]   perSel;
    logic              ext;
    logic              wrOk;
    logic [BYTE_W-1:0] addr;
  } decT;
endpackage

// File: rtl/bwdec_ctrl.sv
module bwdec_ctrl
  import bwdec_pkg::*;
#(
  parameter int unsigned RD_CYC = 4,
  parameter int unsigned WR_LOW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pwrFail,
  input  logic           reqValid,
  input  logic [1:0]     reqKind,
  output bwdec_pkg::strobeT stb
);
  localparam int unsigned WR_CYC = WR_LOW + 2;
  localparam int unsigned CW     = $clog2(WR_CYC + 1);

  logic          busy;
  logic          isWr;
  logic [CW-1:0] cnt;
  logic          reqWr;
  logic          load;
  logic [CW-1:0] lastIdx;
  logic [CW-1:0] nextIdx;
  logic          nextWr;

  always_comb begin
    reqWr   = (reqKind == KIND_WRITE);
    load    = reqValid && !busy && !pwrFail;
    lastIdx = isWr ? CW'(WR_CYC - 1) : CW'(RD_CYC - 1);
    nextIdx = load ? '0 : CW'(cnt + 1'b1);
    nextWr  = load ? reqWr : isWr;
    stb.load = load;
    stb.enOn = !pwrFail && (load || (busy && (cnt != lastIdx)));
    stb.wrOn = stb.enOn && nextWr && (nextIdx >= CW'(1)) && (nextIdx <= CW'(WR_LOW));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      isWr <= 1'b0;
      cnt  <= '0;
    end else if (pwrFail) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      isWr <= reqWr;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == lastIdx) busy <= 1'b0;
      else                cnt  <= cnt + 1'b1;
    end
  end

  // R6: counter never runs past the window of the current kind
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= lastIdx));

  // R6: the last window cycle is followed by an idle cycle
  assert_window_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == lastIdx) |=> !busy);
endmodule

// File: rtl/bwdec_datapath.sv
module bwdec_datapath
  import bwdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrFail,
  input  bwdec_pkg::strobeT stb,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              bigSram,
  input  logic              partMode,
  input  logic              periphSel,
  input  logic [ADDR_W-1:0] progBound,
  output logic [BYTE_W-1:0] byteAddr,
  output logic [N_EN-1:0]   memCeN,
  output logic [N_EN-1:0]   perEnN,
  output logic              ceOnePlainN,
  output logic              rwN,
  output logic              extBus
);
  decT dec;
  decT heldDec;
  decT src;
  logic isData;
  logic effPart;
  logic belowBound;
  logic [N_EN-1:0] memPins;

  always_comb begin
    isData     = (reqKind != KIND_FETCH);
    effPart    = partMode && !bigSram;
    belowBound = (reqAddr < progBound);
    dec        = '0;
    dec.big    = bigSram;
    dec.addr   = reqAddr[BYTE_W-1:0];
    if (isData && periphSel) begin
      dec.perSel = N_EN'(1) << reqAddr[ADDR_W-1 -: 2];
      dec.wrOk   = 1'b1;
    end else if (!isData && !belowBound) begin
      dec.ext = 1'b1;
    end else begin
      dec.memHit  = 1'b1;
      dec.physTop = {isData && !effPart, reqAddr[ADDR_W-1]};
      dec.wrOk    = !(effPart && belowBound);
    end
  end

  always_comb begin
    src = stb.load ? dec : heldDec;
    if (!src.memHit)  memPins = '1;
    else if (src.big) memPins = {1'b1, src.physTop[0], src.physTop[1], 1'b0};
    else              memPins = ~(N_EN'(1) << src.physTop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      heldDec     <= '0;
      byteAddr    <= '0;
      memCeN      <= '1;
      perEnN      <= '1;
      ceOnePlainN <= 1'b1;
      rwN         <= 1'b1;
      extBus      <= 1'b0;
    end else begin
      if (stb.load) heldDec <= dec;
      if (!pwrFail && stb.enOn) begin
        byteAddr    <= src.addr;
        memCeN      <= memPins;
        perEnN      <= ~src.perSel;
        ceOnePlainN <= memPins[0];
        rwN         <= !(stb.wrOn && src.wrOk && !src.ext);
        extBus      <= src.ext;
      end else begin
        memCeN      <= '1;
        perEnN      <= '1;
        ceOnePlainN <= 1'b1;
        rwN         <= 1'b1;
        extBus      <= 1'b0;
      end
    end
  end

  // R7: power fail quiets the whole bus one edge later
  assert_pf_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwrFail |=> (&memCeN && &perEnN && rwN && ceOnePlainN && !extBus));

  // R1: with small SRAMs at most one enable is low
  assert_one_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !heldDec.big |-> ($countones(~{perEnN, memCeN}) <= 1));

  // R2: fourth chip enable unused with the large SRAM
  assert_big_ce4_R2: assert property (@(posedge clk) disable iff (!rst_n)
    heldDec.big |-> memCeN[3]);

  // R4: a write strobe only ever comes with a selected device
  assert_wr_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rwN |-> (!extBus && ($countones(~{perEnN, memCeN}) >= 1)));
endmodule

// File: rtl/bytewide_cs_decoder.sv
module bytewide_cs_decoder
  import bwdec_pkg::*;
#(
  parameter int unsigned RD_CYC = 4,
  parameter int unsigned WR_LOW = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwrFail,
  input  logic        reqValid,
  input  logic [1:0]  reqKind,
  input  logic [15:0] reqAddr,
  input  logic        bigSram,
  input  logic        partMode,
  input  logic        periphSel,
  input  logic [15:0] progBound,
  output logic [14:0] byteAddr,
  output logic [3:0]  memCeN,
  output logic [3:0]  perEnN,
  output logic        ceOnePlainN,
  output logic        rwN,
  output logic        extBus
);
  strobeT stb;

  bwdec_ctrl #(.RD_CYC(RD_CYC), .WR_LOW(WR_LOW)) ctrl (
    .clk(clk), .rst_n(rst_n), .pwrFail(pwrFail),
    .reqValid(reqValid), .reqKind(reqKind), .stb(stb)
  );

  bwdec_datapath dp (
    .clk(clk), .rst_n(rst_n), .pwrFail(pwrFail), .stb(stb),
    .reqKind(reqKind), .reqAddr(reqAddr), .bigSram(bigSram),
    .partMode(partMode), .periphSel(periphSel), .progBound(progBound),
    .byteAddr(byteAddr), .memCeN(memCeN), .perEnN(perEnN),
    .ceOnePlainN(ceOnePlainN), .rwN(rwN), .extBus(extBus)
  );
endmodule

// File: tb/bytewide_cs_decoder_test.sv
`timescale 1ns/1ps
module bytewide_cs_decoder_test;
  localparam int RD_CYC = 4;
  localparam int WR_LOW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrFail = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqKind = 2'd0;
  logic [15:0] reqAddr = 16'h0;
  logic bigSram = 1'b0, partMode = 1'b0, periphSel = 1'b0;
  logic [15:0] progBound = 16'h0;
  logic [14:0] byteAddr;
  logic [3:0] memCeN, perEnN;
  logic ceOnePlainN, rwN, extBus;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  bytewide_cs_decoder #(.RD_CYC(RD_CYC), .WR_LOW(WR_LOW)) uut (
    .clk(clk), .rst_n(rst_n), .pwrFail(pwrFail), .reqValid(reqValid),
    .reqKind(reqKind), .reqAddr(reqAddr), .bigSram(bigSram),
    .partMode(partMode), .periphSel(periphSel), .progBound(progBound),
    .byteAddr(byteAddr), .memCeN(memCeN), .perEnN(perEnN),
    .ceOnePlainN(ceOnePlainN), .rwN(rwN), .extBus(extBus)
  );

  always #5 clk = ~clk;

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      finishRun();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkIdle(input string req);
    chk(req, {perEnN, memCeN}, 8'hFF);
    chk(req, rwN, 1);
    chk(req, extBus, 0);
    chk(req, ceOnePlainN, 1);
  endtask

  // independent model of the decode rules
  task automatic model(input int kind, input logic [15:0] a, input logic big, part, pes,
                       input logic [15:0] bound, output logic [7:0] enN,
                       output logic ext, output logic wrOk, output string tag);
    logic isData, effPart;
    logic [16:0] phys;
    isData = (kind != 0);
    effPart = part && !big;
    enN = 8'hFF; ext = 0; wrOk = 0;
    if (isData && pes) begin
      enN[4 + a[15:14]] = 1'b0; wrOk = 1; tag = "R3";
    end else if (!isData && a >= bound) begin
      ext = 1; tag = "R5";
    end else begin
      phys = {isData && !effPart, a};
      wrOk = !(effPart && a < bound);
      if (big) begin
        enN[0] = 1'b0; enN[1] = phys[16]; enN[2] = phys[15]; enN[3] = 1'b1; tag = "R2";
      end else begin
        enN[phys[16:15]] = 1'b0; tag = "R1";
      end
    end
  endtask

  task automatic runAccess(input int kind, input logic [15:0] a, input logic big, part, pes,
                           input logic [15:0] bound, input bit intrude);
    logic [7:0] enN; logic ext, wrOk; string tag; int len; logic expRw;
    string rwTag;
    model(kind, a, big, part, pes, bound, enN, ext, wrOk, tag);
    len = (kind == 2) ? WR_LOW + 2 : RD_CYC;
    rwTag = (kind == 2 && !wrOk && !ext) ? "R4" : "R6";
    @(negedge clk);
    reqValid = 1; reqKind = 2'(kind); reqAddr = a;
    bigSram = big; partMode = part; periphSel = pes; progBound = bound;
    @(negedge clk);
    reqValid = 0;
    for (int k = 0; k < len; k++) begin
      if (intrude && k == 2) begin
        reqValid = 1; reqKind = 2'd1; reqAddr = ~a; periphSel = ~pes;
      end
      chk(intrude ? "R8" : tag, {perEnN, memCeN}, enN);
      chk(ext ? "R5" : "R6", extBus, ext);
      chk("R9", ceOnePlainN, memCeN[0]);
      if (!ext && k == 0) chk(tag, byteAddr, a[14:0]);
      expRw = !(kind == 2 && wrOk && !ext && k >= 1 && k <= WR_LOW);
      chk(intrude ? "R8" : rwTag, rwN, expRw);
      @(negedge clk);
      reqValid = 0;
    end
    checkIdle(intrude ? "R8" : "R6");
    if (!ext) chk("R6", byteAddr, a[14:0]);
  endtask

  initial begin
    logic [15:0] addrs[10];
    logic [15:0] bounds[2];
    bounds[0] = 16'h6000; bounds[1] = 16'h0000;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", {perEnN, memCeN}, 8'hFF);
    chk("R10", rwN, 1);
    chk("R10", extBus, 0);
    chk("R10", byteAddr, 0);
    chk("R10", ceOnePlainN, 1);
    rst_n = 1;
    @(negedge clk);
    checkIdle("R10");

    // sweep: R1 R2 R3 R4 R5 R6 R9
    for (int b = 0; b < 2; b++) begin
      addrs = '{16'h0000, 16'h3FFF, 16'h4000, 16'h7FFF, 16'h8000,
                16'hBFFF, 16'hC000, 16'hFFFF, bounds[b] - 16'h1, bounds[b]};
      for (int cfg = 0; cfg < 8; cfg++)
        for (int kind = 0; kind < 4; kind++)
          for (int i = 0; i < 10; i++)
            runAccess(kind, addrs[i], cfg[2], cfg[1], cfg[0], bounds[b],
                      (kind == 2) || (i == 3));
    end

    // R7: power fail in the middle of a write strobe
    @(negedge clk);
    reqValid = 1; reqKind = 2'd2; reqAddr = 16'h1234;
    bigSram = 0; partMode = 0; periphSel = 0; progBound = 16'h6000;
    @(negedge clk);
    reqValid = 0;
    chk("R7", memCeN, 4'b1011);
    repeat (3) @(negedge clk);
    chk("R7", rwN, 0);
    pwrFail = 1;
    @(negedge clk);
    checkIdle("R7");
    reqValid = 1; reqKind = 2'd1; reqAddr = 16'h0100;
    @(negedge clk);
    checkIdle("R7");
    @(negedge clk);
    checkIdle("R7");
    pwrFail = 0; reqValid = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      checkIdle("R7");
    end
    // recovery after the fail
    runAccess(2, 16'h0042, 1'b0, 1'b1, 1'b0, 16'h0010, 1'b0);
    runAccess(0, 16'h0008, 1'b1, 1'b0, 1'b0, 16'h0010, 1'b0);
    finishRun();
  end
endmodule